// File: doc/BRIEF.md
# Renaming Reservation Stations with Result-Bus Capture

This block sits between an in-order operation queue and a set of arithmetic units. Each cycle the queue may offer one operation, tagged as either adder class or multiplier class. The operation is accepted only if a free station of that class exists. On acceptance the block looks up both source registers in its register rename-status table. A source with no pending writer takes its value from the register file read ports. A source with a pending writer takes the tag of the station that will produce it. The destination register is then renamed to the accepting station's tag. Register names therefore disappear at issue, and later writes to the same register cannot create write-after-read or write-after-write stalls.

Every station watches a shared result bus that carries a data word and a source tag. A station waiting on that tag captures the word in the same cycle as every other waiting station. The rename-status entry that still names that tag is cleared in the same cycle. The station whose own tag is broadcast becomes free. A station whose two operands are both present requests dispatch on its class's dispatch port. Only one station per class dispatches per cycle, and each station dispatches only once.

The arithmetic units, the register file storage, the bus arbiter and the memory buffers are outside this block. The block only reads register values, consumes broadcasts and raises dispatch requests.

Top module: `rs_rename_core`

## Requirements
- R1: After a synchronous active-low reset every station is free, neither dispatch output is asserted, and every rename-status entry is empty, so the first readers of any register take the register-file value.
- R2: `iss_accept` is high only when `iss_valid` is high and a station of the requested class is free (`iss_class` 0 = adder, 1 = multiplier). Adder stations carry tags 1..3 and multiplier stations carry tags 4..5. The free station with the lowest tag is the one taken.
- R3: At issue, a source whose rename-status entry is empty takes the value on its register-file read port (`rf_val1` for `iss_src1`, `rf_val2` for `iss_src2`) and counts as present.
- R4: At issue, the destination's rename-status entry is set to the accepting station's tag. A later operation reading that register records that tag instead of a value.
- R5: A station requests dispatch only when both of its operands are present. Dispatch appears on the cycle after the last operand arrives and presents the station tag, the operation code and both operand values.
- R6: On a result broadcast (`cdb_valid`), every station waiting on `cdb_tag`, in either operand, captures `cdb_data` in the same cycle.
- R7: A broadcast carrying a busy station's own tag frees that station, so it may accept a new operation from the next cycle.
- R8: A broadcast clears a rename-status entry only if the entry holds the broadcast tag. A register renamed again to a newer producer keeps the newer tag.
- R9: If a source's producer broadcasts in the same cycle that the consumer issues, the consumer captures the broadcast value directly and does not wait for the tag.
- R10: When several stations of one class are ready, the lowest tag dispatches first. At most one station per class dispatches per cycle, and each station dispatches once per issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Operation offered by the queue this cycle |
| iss_class | input | 1 | Station class: 0 adder, 1 multiplier |
| iss_op | input | 3 | Operation code carried to dispatch |
| iss_dst | input | 4 | Destination register number |
| iss_src1 | input | 4 | First source register number |
| iss_src2 | input | 4 | Second source register number |
| rf_val1 | input | 64 | Register-file value of `iss_src1` |
| rf_val2 | input | 64 | Register-file value of `iss_src2` |
| iss_accept | output | 1 | Offered operation is taken at this clock edge |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 4 | Tag of the broadcasting station (nonzero) |
| cdb_data | input | 64 | Broadcast result value |
| add_go | output | 1 | An adder station dispatches this cycle |
| add_go_tag | output | 4 | Tag of the dispatching adder station |
| add_go_op | output | 3 | Its operation code |
| add_go_vj | output | 64 | Its first operand |
| add_go_vk | output | 64 | Its second operand |
| mul_go | output | 1 | A multiplier station dispatches this cycle |
| mul_go_tag | output | 4 | Tag of the dispatching multiplier station |
| mul_go_op | output | 3 | Its operation code |
| mul_go_vj | output | 64 | Its first operand |
| mul_go_vk | output | 64 | Its second operand |

## Verification
Operations whose sources are all idle registers show whether register-file values and station tags pass through correctly. A chain that waits on a multiplier result, with one consumer waiting on both operands and another waiting on its second operand only, shows whether one broadcast reaches every waiting field together and whether the lower tag dispatches first. Filling the adder class and then freeing stations out of order separates the structural stall from the choice of the lowest free station. Renaming a register twice and broadcasting the older tag, and separately issuing a consumer in the very cycle its producer broadcasts, shows the difference between a tag-matched clear and a blind clear, and between bypass capture and a lost wakeup.

// File: rtl/rs_pkg.sv
// Package: shared class encoding and default sizes for the reservation
// station block. Assumes tag 0 is reserved to mean "value present".
package rs_pkg;
    localparam int unsigned RS_DATA_W = 64;
    localparam int unsigned RS_TAG_W  = 4;
    localparam logic CLS_ADD = 1'b0;
    localparam logic CLS_MUL = 1'b1;
endpackage

// File: rtl/rs_pick.sv
// Lowest-index picker: reports whether any request bit is set and the
// index of the lowest one. Purely combinational; assumes N >= 1.
module rs_pick #(
    parameter int N     = 3,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_rename_table.sv
// Rename-status table: one producer tag per architectural register, zero
// meaning no pending writer. Two combinational lookups; a new rename wins
// over a same-cycle clear; a clear needs an exact tag match.
module rs_rename_table #(
    parameter int NUM_REGS = 16,
    parameter int TAG_W    = 4,
    parameter int REG_AW   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] rd_a1,
    input  logic [REG_AW-1:0] rd_a2,
    output logic [TAG_W-1:0]  rd_t1,
    output logic [TAG_W-1:0]  rd_t2,
    input  logic              set_en,
    input  logic [REG_AW-1:0] set_addr,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag
);
    logic [TAG_W-1:0] owner_q [NUM_REGS];

    // Lookups see the state before this cycle's update.
    assign rd_t1 = owner_q[rd_a1];
    assign rd_t2 = owner_q[rd_a2];

    // Per-register update: rename on issue, clear on matching broadcast.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_REGS; r++) begin
            if (!rst_n) begin
                owner_q[r] <= '0;
            end else if (set_en && set_addr == REG_AW'(r)) begin
                owner_q[r] <= set_tag;
            end else if (cdb_valid && owner_q[r] != '0 && owner_q[r] == cdb_tag) begin
                owner_q[r] <= '0;
            end
        end
    end
endmodule

// File: rtl/rs_station.sv
// One reservation station: holds op, two operand values and two producer
// tags (zero tag = value present). Captures matching broadcasts, frees
// itself when its own tag is broadcast, and requests dispatch once.
module rs_station #(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4,
    parameter int OP_W   = 3,
    parameter int MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [OP_W-1:0]   ld_op,
    input  logic [DATA_W-1:0] ld_vj,
    input  logic [TAG_W-1:0]  ld_qj,
    input  logic [DATA_W-1:0] ld_vk,
    input  logic [TAG_W-1:0]  ld_qk,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              take,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] vj,
    output logic [DATA_W-1:0] vk
);
    logic              busy_q, sent_q;
    logic [OP_W-1:0]   op_q;
    logic [DATA_W-1:0] vj_q, vk_q;
    logic [TAG_W-1:0]  qj_q, qk_q;

    // Station state: load on issue, otherwise snoop the result bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sent_q <= 1'b0;
            op_q   <= '0;
            vj_q   <= '0;
            vk_q   <= '0;
            qj_q   <= '0;
            qk_q   <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            sent_q <= 1'b0;
            op_q   <= ld_op;
            vj_q   <= ld_vj;
            qj_q   <= ld_qj;
            vk_q   <= ld_vk;
            qk_q   <= ld_qk;
        end else begin
            if (take) begin
                sent_q <= 1'b1;
            end
            if (cdb_valid && busy_q && cdb_tag == TAG_W'(MY_TAG)) begin
                busy_q <= 1'b0;
            end
            if (cdb_valid && qj_q != '0 && cdb_tag == qj_q) begin
                vj_q <= cdb_data;
                qj_q <= '0;
            end
            if (cdb_valid && qk_q != '0 && cdb_tag == qk_q) begin
                vk_q <= cdb_data;
                qk_q <= '0;
            end
        end
    end

    // Ready once both tags are zero and it has not been sent yet.
    assign ready = busy_q && !sent_q && qj_q == '0 && qk_q == '0;
    assign busy  = busy_q;
    assign op    = op_q;
    assign vj    = vj_q;
    assign vk    = vk_q;
endmodule

// File: rtl/rs_rename_core.sv
// Top: adder and multiplier reservation stations with a rename-status
// table. Accepts one operation per cycle into the lowest free station of
// its class, renames sources to values or tags, snoops the result bus and
// dispatches the lowest ready station per class. Assumes cdb_tag is never
// zero when cdb_valid is high, and that dispatched operations are always
// taken by the arithmetic units.
module rs_rename_core #(
    parameter int DATA_W   = rs_pkg::RS_DATA_W,
    parameter int TAG_W    = rs_pkg::RS_TAG_W,
    parameter int OP_W     = 3,
    parameter int NUM_REGS = 16,
    parameter int N_ADD    = 3,
    parameter int N_MUL    = 2,
    parameter int REG_AW   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic              iss_class,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [REG_AW-1:0] iss_dst,
    input  logic [REG_AW-1:0] iss_src1,
    input  logic [REG_AW-1:0] iss_src2,
    input  logic [DATA_W-1:0] rf_val1,
    input  logic [DATA_W-1:0] rf_val2,
    output logic              iss_accept,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              add_go,
    output logic [TAG_W-1:0]  add_go_tag,
    output logic [OP_W-1:0]   add_go_op,
    output logic [DATA_W-1:0] add_go_vj,
    output logic [DATA_W-1:0] add_go_vk,
    output logic              mul_go,
    output logic [TAG_W-1:0]  mul_go_tag,
    output logic [OP_W-1:0]   mul_go_op,
    output logic [DATA_W-1:0] mul_go_vj,
    output logic [DATA_W-1:0] mul_go_vk
);
    import rs_pkg::*;

    localparam int NST    = N_ADD + N_MUL;
    localparam int AIDX_W = (N_ADD > 1) ? $clog2(N_ADD) : 1;
    localparam int MIDX_W = (N_MUL > 1) ? $clog2(N_MUL) : 1;
    localparam int SLOT_W = (NST > 1) ? $clog2(NST) : 1;

    logic [NST-1:0]    st_busy, st_ready, st_load, st_take;
    logic [OP_W-1:0]   st_op [NST];
    logic [DATA_W-1:0] st_vj [NST];
    logic [DATA_W-1:0] st_vk [NST];

    logic              add_free_any, mul_free_any, add_rdy_any, mul_rdy_any;
    logic [AIDX_W-1:0] add_free_idx, add_rdy_idx;
    logic [MIDX_W-1:0] mul_free_idx, mul_rdy_idx;
    logic [SLOT_W-1:0] iss_slot;
    logic [TAG_W-1:0]  iss_tag;
    logic [TAG_W-1:0]  look_t1, look_t2;
    logic [DATA_W-1:0] res_vj, res_vk;
    logic [TAG_W-1:0]  res_qj, res_qk;

    // Free and ready searches, one picker per class and purpose.
    rs_pick #(.N(N_ADD), .IDX_W(AIDX_W)) u_pick_add_free (
        .req(~st_busy[N_ADD-1:0]), .any(add_free_any), .idx(add_free_idx));
    rs_pick #(.N(N_MUL), .IDX_W(MIDX_W)) u_pick_mul_free (
        .req(~st_busy[NST-1:N_ADD]), .any(mul_free_any), .idx(mul_free_idx));
    rs_pick #(.N(N_ADD), .IDX_W(AIDX_W)) u_pick_add_rdy (
        .req(st_ready[N_ADD-1:0]), .any(add_rdy_any), .idx(add_rdy_idx));
    rs_pick #(.N(N_MUL), .IDX_W(MIDX_W)) u_pick_mul_rdy (
        .req(st_ready[NST-1:N_ADD]), .any(mul_rdy_any), .idx(mul_rdy_idx));

    // Acceptance and target station for the offered operation.
    always_comb begin
        if (iss_class == CLS_MUL) begin
            iss_accept = iss_valid && mul_free_any;
            iss_slot   = SLOT_W'(N_ADD) + SLOT_W'(mul_free_idx);
        end else begin
            iss_accept = iss_valid && add_free_any;
            iss_slot   = SLOT_W'(add_free_idx);
        end
        iss_tag = TAG_W'(iss_slot) + TAG_W'(1);
    end

    rs_rename_table #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .REG_AW(REG_AW)) u_rename (
        .clk(clk), .rst_n(rst_n),
        .rd_a1(iss_src1), .rd_a2(iss_src2), .rd_t1(look_t1), .rd_t2(look_t2),
        .set_en(iss_accept), .set_addr(iss_dst), .set_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag));

    // Source renaming: register value, same-cycle bus value, or tag.
    always_comb begin
        if (look_t1 == '0) begin
            res_vj = rf_val1;  res_qj = '0;
        end else if (cdb_valid && cdb_tag == look_t1) begin
            res_vj = cdb_data; res_qj = '0;
        end else begin
            res_vj = '0;       res_qj = look_t1;
        end
        if (look_t2 == '0) begin
            res_vk = rf_val2;  res_qk = '0;
        end else if (cdb_valid && cdb_tag == look_t2) begin
            res_vk = cdb_data; res_qk = '0;
        end else begin
            res_vk = '0;       res_qk = look_t2;
        end
    end

    // Station array; station i answers to tag i+1.
    for (genvar i = 0; i < NST; i++) begin : g_st
        assign st_load[i] = iss_accept && iss_slot == SLOT_W'(i);
        if (i < N_ADD) begin : g_add
            assign st_take[i] = add_rdy_any && add_rdy_idx == AIDX_W'(i);
        end else begin : g_mul
            assign st_take[i] = mul_rdy_any && mul_rdy_idx == MIDX_W'(i - N_ADD);
        end
        rs_station #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .MY_TAG(i + 1)) u_st (
            .clk(clk), .rst_n(rst_n),
            .load(st_load[i]), .ld_op(iss_op),
            .ld_vj(res_vj), .ld_qj(res_qj), .ld_vk(res_vk), .ld_qk(res_qk),
            .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
            .take(st_take[i]),
            .busy(st_busy[i]), .ready(st_ready[i]),
            .op(st_op[i]), .vj(st_vj[i]), .vk(st_vk[i]));
    end

    // Dispatch ports: the chosen station of each class.
    assign add_go     = add_rdy_any;
    assign add_go_tag = TAG_W'(add_rdy_idx) + TAG_W'(1);
    assign add_go_op  = st_op[add_rdy_idx];
    assign add_go_vj  = st_vj[add_rdy_idx];
    assign add_go_vk  = st_vk[add_rdy_idx];
    assign mul_go     = mul_rdy_any;
    assign mul_go_tag = TAG_W'(mul_rdy_idx) + TAG_W'(N_ADD + 1);
    assign mul_go_op  = st_op[N_ADD + int'(mul_rdy_idx)];
    assign mul_go_vj  = st_vj[N_ADD + int'(mul_rdy_idx)];
    assign mul_go_vk  = st_vk[N_ADD + int'(mul_rdy_idx)];
endmodule

// File: rtl/rs_rename_core_chk.sv
// Checker: temporal properties of the reservation station block, tied to
// the top through bind. Observes ports and the station busy vector.
module rs_rename_core_chk #(
    parameter int TAG_W = 4,
    parameter int N_ADD = 3,
    parameter int N_MUL = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   iss_valid,
    input logic                   iss_class,
    input logic                   iss_accept,
    input logic                   cdb_valid,
    input logic [TAG_W-1:0]       cdb_tag,
    input logic                   add_go,
    input logic [TAG_W-1:0]       add_go_tag,
    input logic                   mul_go,
    input logic [TAG_W-1:0]       mul_go_tag,
    input logic [N_ADD+N_MUL-1:0] st_busy
);
    localparam int NST = N_ADD + N_MUL;

    AST_ADD_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_class && (&st_busy[N_ADD-1:0])) |-> !iss_accept); // R2
    AST_MUL_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_class && (&st_busy[NST-1:N_ADD])) |-> !iss_accept); // R2
    AST_ADD_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        add_go |-> (add_go_tag >= 1 && int'(add_go_tag) <= N_ADD)); // R2
    AST_ADD_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        add_go |-> st_busy[int'(add_go_tag) - 1]); // R5
    AST_ADD_GO_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        add_go |=> !(add_go && add_go_tag == $past(add_go_tag))); // R10
    AST_MUL_GO_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |=> !(mul_go && mul_go_tag == $past(mul_go_tag))); // R10
    AST_FREE_ON_OWN_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && cdb_tag != '0 && int'(cdb_tag) <= NST && st_busy[int'(cdb_tag) - 1])
        |=> !st_busy[int'($past(cdb_tag)) - 1]); // R7
endmodule

bind rs_rename_core rs_rename_core_chk #(.TAG_W(TAG_W), .N_ADD(N_ADD), .N_MUL(N_MUL)) u_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_accept(iss_accept), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .add_go(add_go), .add_go_tag(add_go_tag), .mul_go(mul_go),
    .mul_go_tag(mul_go_tag), .st_busy(st_busy));

// File: tb/rs_rename_core_bench.sv
// Directed bench: one task per scenario, each starting from reset.
module rs_rename_core_bench;
    localparam int DW = 64;
    localparam int TW = 4;
    localparam int OW = 3;
    localparam int AW = 4;
    localparam logic [DW-1:0] RF_BASE = 64'hF00D_0000_0000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0, iss_class = 1'b0;
    logic [OW-1:0] iss_op = '0;
    logic [AW-1:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [DW-1:0] rf_val1, rf_val2;
    logic          iss_accept;
    logic          cdb_valid = 1'b0;
    logic [TW-1:0] cdb_tag = '0;
    logic [DW-1:0] cdb_data = '0;
    logic          add_go, mul_go;
    logic [TW-1:0] add_go_tag, mul_go_tag;
    logic [OW-1:0] add_go_op, mul_go_op;
    logic [DW-1:0] add_go_vj, add_go_vk, mul_go_vj, mul_go_vk;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Bench register file: fixed contents derived from the register number.
    function automatic logic [DW-1:0] rfv(input int r);
        return RF_BASE | DW'(r);
    endfunction
    assign rf_val1 = rfv(int'(iss_src1));
    assign rf_val2 = rfv(int'(iss_src2));

    rs_rename_core u_rs_rename_core (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .rf_val1(rf_val1), .rf_val2(rf_val2), .iss_accept(iss_accept),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .add_go(add_go), .add_go_tag(add_go_tag), .add_go_op(add_go_op),
        .add_go_vj(add_go_vj), .add_go_vk(add_go_vk),
        .mul_go(mul_go), .mul_go_tag(mul_go_tag), .mul_go_op(mul_go_op),
        .mul_go_vj(mul_go_vj), .mul_go_vk(mul_go_vk));

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        iss_valid = 1'b0;
        cdb_valid = 1'b0;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    // Offer one operation, check acceptance, let the edge pass.
    task automatic issue(input logic cls, input int op, input int dst,
                         input int s1, input int s2, input logic exp_acc, input string req);
        iss_valid = 1'b1;
        iss_class = cls;
        iss_op    = OW'(op);
        iss_dst   = AW'(dst);
        iss_src1  = AW'(s1);
        iss_src2  = AW'(s2);
        #1;
        chk(req, "iss_accept", DW'(iss_accept), DW'(exp_acc));
        tick();
        iss_valid = 1'b0;
    endtask

    task automatic bcast(input int tag, input logic [DW-1:0] data);
        cdb_valid = 1'b1;
        cdb_tag   = TW'(tag);
        cdb_data  = data;
        tick();
        cdb_valid = 1'b0;
    endtask

    task automatic chk_add(input string req, input int tag,
                           input logic [DW-1:0] vj, input logic [DW-1:0] vk);
        chk(req, "add_go", DW'(add_go), 64'd1);
        chk(req, "add_go_tag", DW'(add_go_tag), DW'(tag));
        chk(req, "add_go_vj", add_go_vj, vj);
        chk(req, "add_go_vk", add_go_vk, vk);
    endtask

    // R1, R3, R5, R10: reset state and a single independent operation.
    task automatic t_reset_basic();
        do_reset();
        chk("R1", "add_go after reset", DW'(add_go), 64'd0);
        chk("R1", "mul_go after reset", DW'(mul_go), 64'd0);
        chk("R1", "iss_accept idle", DW'(iss_accept), 64'd0);
        issue(1'b0, 3, 1, 2, 3, 1'b1, "R1");
        chk_add("R3", 1, rfv(2), rfv(3));
        chk("R5", "add_go_op", DW'(add_go_op), 64'd3);
        tick();
        chk("R10", "no second dispatch", DW'(add_go), 64'd0);
        chk("R10", "mul_go idle", DW'(mul_go), 64'd0);
    endtask

    // R4, R5, R6, R10, R8, R7: wait on a multiplier result, wake together.
    task automatic t_wakeup();
        do_reset();
        issue(1'b1, 1, 1, 2, 3, 1'b1, "R2");
        chk("R2", "mul_go", DW'(mul_go), 64'd1);
        chk("R2", "mul_go_tag", DW'(mul_go_tag), 64'd4);
        chk("R3", "mul_go_vj", mul_go_vj, rfv(2));
        issue(1'b0, 2, 5, 1, 1, 1'b1, "R4");
        chk("R4", "add waits on both", DW'(add_go), 64'd0);
        issue(1'b0, 4, 6, 7, 1, 1'b1, "R4");
        chk("R5", "add waits on k", DW'(add_go), 64'd0);
        tick();
        chk("R5", "still waiting", DW'(add_go), 64'd0);
        bcast(4, 64'hDEAD_BEEF_0000_0004);
        chk_add("R6", 1, 64'hDEAD_BEEF_0000_0004, 64'hDEAD_BEEF_0000_0004);
        chk("R6", "add_go_op", DW'(add_go_op), 64'd2);
        tick();
        chk_add("R10", 2, rfv(7), 64'hDEAD_BEEF_0000_0004);
        tick();
        chk("R10", "drained", DW'(add_go), 64'd0);
        issue(1'b1, 5, 9, 1, 1, 1'b1, "R7");
        chk("R7", "mul_go_tag reused", DW'(mul_go_tag), 64'd4);
        chk("R8", "cleared entry reads rf", mul_go_vj, rfv(1));
    endtask

    // R2, R7: fill the adder class, stall, free out of order.
    task automatic t_structural();
        do_reset();
        issue(1'b0, 0, 1, 0, 0, 1'b1, "R2");
        chk("R2", "first tag", DW'(add_go_tag), 64'd1);
        issue(1'b0, 0, 2, 0, 0, 1'b1, "R2");
        chk("R2", "second tag", DW'(add_go_tag), 64'd2);
        issue(1'b0, 0, 3, 0, 0, 1'b1, "R2");
        chk("R2", "third tag", DW'(add_go_tag), 64'd3);
        issue(1'b0, 0, 4, 0, 0, 1'b0, "R2");
        chk("R2", "no dispatch after stall", DW'(add_go), 64'd0);
        iss_valid = 1'b1;
        iss_class = 1'b1;
        #1;
        chk("R2", "mul still free", DW'(iss_accept), 64'd1);
        iss_valid = 1'b0;
        bcast(3, 64'h3);
        bcast(1, 64'h1);
        issue(1'b0, 6, 4, 5, 6, 1'b1, "R7");
        chk_add("R7", 1, rfv(5), rfv(6));
        issue(1'b0, 6, 4, 8, 9, 1'b1, "R7");
        chk_add("R7", 3, rfv(8), rfv(9));
    endtask

    // R8: a second rename of the same register survives the older broadcast.
    task automatic t_newer_owner();
        do_reset();
        issue(1'b0, 1, 1, 2, 3, 1'b1, "R8");
        issue(1'b0, 1, 1, 4, 5, 1'b1, "R8");
        bcast(1, 64'hAAAA);
        issue(1'b0, 2, 7, 1, 2, 1'b1, "R8");
        chk("R8", "consumer waits on newer tag", DW'(add_go), 64'd0);
        tick();
        chk("R8", "still waiting", DW'(add_go), 64'd0);
        bcast(2, 64'hBBBB);
        chk_add("R8", 1, 64'hBBBB, rfv(2));
        tick();
        issue(1'b1, 0, 8, 1, 1, 1'b1, "R8");
        chk("R8", "entry cleared by newer tag", mul_go_vj, rfv(1));
    endtask

    // R9: consumer issues while its producer broadcasts.
    task automatic t_bypass();
        do_reset();
        issue(1'b1, 1, 2, 0, 0, 1'b1, "R9");
        chk("R9", "producer tag", DW'(mul_go_tag), 64'd4);
        cdb_valid = 1'b1;
        cdb_tag   = 4'd4;
        cdb_data  = 64'hCAFE_F00D;
        issue(1'b0, 3, 3, 2, 5, 1'b1, "R9");
        cdb_valid = 1'b0;
        chk_add("R9", 1, 64'hCAFE_F00D, rfv(5));
        issue(1'b1, 2, 9, 2, 2, 1'b1, "R9");
        chk("R9", "status cleared", mul_go_vj, rfv(2));
    endtask

    initial begin
        t_reset_basic();
        t_wakeup();
        t_structural();
        t_newer_owner();
        t_bypass();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200_000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule